// File: doc/BRIEF.md
# Extended-Data-Out DRAM with Four Column Strobes

This block is a clock-sampled functional model of a 4-bit-wide asynchronous DRAM. All strobes (row strobe, four column strobes, write and output enable, all active low) are sampled on a fast internal clock, and edges are found by comparing each sample with the previous one. On every row-strobe falling edge the block decides what kind of cycle starts. If every column strobe is high, the cycle is a normal access and the row address is taken. If any column strobe is already low, the cycle is an internal-counter refresh, and test-mode entry is selected when write is also low.

Inside an access, a column strobe falling after all strobes were high takes a new column, so one row can serve many columns (page mode). Each data bit has its own column strobe that gates both the read drive and the write capture of that bit. Read data stays driven after the column strobe rises, and the drive ends only when both the row strobe and that bit's column strobe are high. Writes can be early (write low before the strobe falls, outputs stay off), write-strobe controlled, or read-modify-write. Holding the row strobe low in a refresh cycle for a parameterized number of clocks puts the block into self-refresh. The array is kept small so that simulation stays fast.

Top module: `edo_quad_cas_dram`

## Requirements
- R1: After reset, all four output enables are 0, the refresh row is 0, and the test-mode and self-refresh flags are 0.
- R2: A row-strobe fall with all column strobes high takes the row from the low ROW_W address bits. The first column-strobe fall then takes the column from the low COL_W address bits. Bit i reads the bit i last written at word row*2^COL_W+col, and dq_out and dq_oe show it one clock after that fall.
- R3: Column strobe i only drives and only writes data bit i. Bits whose strobe stays high keep their stored value, and their output enables stay 0.
- R4: If write is low when a column strobe falls in an access, that bit stores dq_in at that edge and its output stays disabled for the access.
- R5: Write falling while column strobe i is low stores dq_in bit i into the current word. Data read earlier in the same access is seen on the outputs before the write.
- R6: Once a bit is driven, it stays driven while the row strobe or its column strobe is low. It turns off one clock after both are sampled high. Output enable high or write low forces dq_oe to 0.
- R7: In page mode, each new column-strobe fall after all strobes were high takes a new column with the row kept, and delivers that column's data.
- R8: A row-strobe fall with any column strobe low starts a refresh. This cycle reads and writes nothing, and its address is ignored. The refresh row increments by one at its row-strobe rise and wraps at 2^ROW_W.
- R9: A refresh start with write low sets the test-mode flag and does not advance the refresh row. A refresh start with write high clears the flag.
- R10: In a refresh cycle, every SELF_CYC clocks of row strobe held low set the self-refresh flag and advance the refresh row by one. The flag clears at the row-strobe rise, which adds the normal increment.
- R11: Hidden refresh: the row strobe rises and falls again while a column strobe stays low after a read. The read data stays driven, and the refresh row advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 4 | Column strobe per data bit, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 4 | Data from the bus for writes |
| dq_out | output | 4 | Read data value |
| dq_oe | output | 4 | Per-bit output drive enable |
| refresh_row | output | ROW_W | Internal refresh row counter |
| test_mode | output | 1 | Parallel test mode entered |
| self_refresh | output | 1 | Self-refresh in progress |

## Verification
The bench builds the block with ROW_W=3, COL_W=2 and SELF_CYC=8. With only eight rows, nine refresh cycles carry the counter across its wrap. With an eight-clock self-refresh interval, a row strobe held low for nineteen clocks gives exactly two self-refresh steps plus the closing increment. A small array also lets row and column bits overlap on the shared address bus, so a swapped or mis-sliced address shows up as wrong read data.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2,
    CYC_TESTIN  = 2'd3
  } cyc_e;

  // next refresh row, wrapping at the row count
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // flat word index from row and column
  function automatic int unsigned word_index(int unsigned row, int unsigned col, int col_w);
    return (row << col_w) | col;
  endfunction

endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  output logic             ras_fall,
  output logic             ras_rise,
  output logic [LANES-1:0] cas_fall,
  output logic             we_fall,
  output logic             cas_idle_q
);
  logic             ras_q;
  logic [LANES-1:0] cas_q;
  logic             we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= '1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign ras_fall   = ras_q & ~ras_n;
  assign ras_rise   = ~ras_q & ras_n;
  assign cas_fall   = cas_q & ~cas_n;
  assign we_fall    = we_q & ~we_n;
  assign cas_idle_q = &cas_q;
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_dram_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ROW_W    = 5,
  parameter int COL_W    = 4,
  parameter int ADDR_W   = 5,
  parameter int SELF_CYC = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_idle_q,
  output logic             in_access,
  output logic [ROW_W-1:0] acc_row,
  output logic [COL_W-1:0] acc_col,
  output logic [ROW_W-1:0] ref_row,
  output logic             self_ref,
  output logic             test_mode
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int TMR_W = (SELF_CYC > 2) ? $clog2(SELF_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SELF_CYC - 1);

  cyc_e             cyc_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [TMR_W-1:0] tmr_q;
  logic             cas_any_low;
  logic             first_fall;
  logic [ROW_W-1:0] ref_next;

  assign cas_any_low = (cas_n != '1);
  assign in_access   = (cyc_q == CYC_ACCESS) && !ras_n;
  assign first_fall  = in_access && cas_idle_q && cas_any_low;
  assign ref_next    = ROW_W'(wrap_inc(32'(ref_row), ROWS));
  assign acc_row     = row_q;
  assign acc_col     = first_fall ? addr[COL_W-1:0] : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= CYC_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      tmr_q     <= '0;
      ref_row   <= '0;
      self_ref  <= 1'b0;
      test_mode <= 1'b0;
    end else if (ras_fall) begin
      tmr_q <= '0;
      if (cas_any_low) begin
        cyc_q     <= we_n ? CYC_REFRESH : CYC_TESTIN;
        test_mode <= !we_n;
      end else begin
        cyc_q <= CYC_ACCESS;
        row_q <= addr[ROW_W-1:0];
      end
    end else if (ras_rise) begin
      if (cyc_q == CYC_REFRESH) ref_row <= ref_next;
      cyc_q    <= CYC_IDLE;
      self_ref <= 1'b0;
    end else begin
      if (first_fall) col_q <= addr[COL_W-1:0];
      if (cyc_q == CYC_REFRESH && !ras_n) begin
        if (tmr_q == TMR_LAST) begin
          tmr_q    <= '0;
          self_ref <= 1'b1;
          ref_row  <= ref_next;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  p_refresh_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && cyc_q == CYC_REFRESH) |=> (ref_row != $past(ref_row)));
  p_no_access_cbr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_any_low) |=> !in_access);
  p_test_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_any_low && !we_n) |=> test_mode);
  p_selfref_scope_r10: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> (cyc_q == CYC_REFRESH));
endmodule

// File: rtl/edo_dq_lane.sv
module edo_dq_lane #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             in_access,
  input  logic             cas_fall,
  input  logic             we_fall,
  input  logic [IDX_W-1:0] idx,
  input  logic             din,
  output logic             dout,
  output logic             dq_oe
);
  localparam int DEPTH = 1 << IDX_W;

  logic mem [DEPTH];
  logic drive_q;
  logic dout_q;
  logic wr_en;

  assign wr_en = in_access && ((cas_fall && !we_n) || (we_fall && !cas_n));

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      dout_q  <= 1'b0;
    end else if (in_access && cas_fall) begin
      drive_q <= we_n;
      if (we_n) dout_q <= mem[idx];
    end else if (ras_n && cas_n) begin
      drive_q <= 1'b0;
    end
  end

  assign dout  = dout_q;
  assign dq_oe = drive_q && !oe_n && we_n;

  p_early_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && cas_fall && !we_n) |=> !dq_oe);
  p_edo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && (!ras_n || !cas_n) && !(in_access && cas_fall)) |=> drive_q);
  p_hiz_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> !dq_oe);
endmodule

// File: rtl/edo_quad_cas_dram.sv
module edo_quad_cas_dram
  import edo_dram_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int COL_W    = 4,
  parameter int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int SELF_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [3:0]        cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic [ROW_W-1:0]  refresh_row,
  output logic              test_mode,
  output logic              self_refresh
);
  localparam int LANES = 4;
  localparam int IDX_W = ROW_W + COL_W;

  logic             ras_fall, ras_rise, we_fall, cas_idle_q, in_access;
  logic [LANES-1:0] cas_fall;
  logic [ROW_W-1:0] acc_row;
  logic [COL_W-1:0] acc_col;
  logic [IDX_W-1:0] word_idx;

  edo_strobe_edges #(.LANES(LANES)) u_edges (
    .clk, .rst_n, .ras_n, .cas_n, .we_n,
    .ras_fall, .ras_rise, .cas_fall, .we_fall, .cas_idle_q
  );

  edo_cycle_ctrl #(
    .LANES(LANES), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .SELF_CYC(SELF_CYC)
  ) u_ctrl (
    .clk, .rst_n, .ras_n, .cas_n, .we_n, .addr,
    .ras_fall, .ras_rise, .cas_idle_q,
    .in_access, .acc_row, .acc_col,
    .ref_row(refresh_row), .self_ref(self_refresh), .test_mode
  );

  assign word_idx = IDX_W'(word_index(32'(acc_row), 32'(acc_col), COL_W));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_dq_lane #(.IDX_W(IDX_W)) u_lane (
      .clk, .rst_n, .ras_n,
      .cas_n(cas_n[g]), .we_n, .oe_n, .in_access,
      .cas_fall(cas_fall[g]), .we_fall,
      .idx(word_idx), .din(dq_in[g]),
      .dout(dq_out[g]), .dq_oe(dq_oe[g])
    );
  end
endmodule

// File: tb/test_edo_quad_cas_dram.sv
module test_edo_quad_cas_dram;
  localparam int ROW_W = 3, COL_W = 2, ADDR_W = 3, SELF_CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0] cas_n = 4'hF, dq_in = 4'h0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] dq_out, dq_oe;
  logic [ROW_W-1:0] refresh_row;
  logic test_mode, self_refresh;

  int checks = 0, errors = 0;
  int exp_ref = 0;

  always #10 clk = ~clk;

  edo_quad_cas_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .SELF_CYC(SELF_CYC))
  i_edo_quad_cas_dram (
    .clk, .rst_n, .ras_n, .cas_n, .we_n, .oe_n, .addr, .dq_in,
    .dq_out, .dq_oe, .refresh_row, .test_mode, .self_refresh
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_word(int row, int col, logic [3:0] mask, logic [3:0] data);
    tick(); addr = ADDR_W'(row); ras_n = 0;
    tick(); addr = ADDR_W'(col); we_n = 0; dq_in = data; cas_n = ~mask;
    tick(); chk("R4 early write keeps outputs off", 32'(dq_oe), 0);
    cas_n = 4'hF; ras_n = 1; we_n = 1;
    tick();
  endtask

  task automatic rd_check(string req, int row, int col, logic [3:0] exp);
    tick(); addr = ADDR_W'(row); ras_n = 0;
    tick(); addr = ADDR_W'(col); cas_n = 4'h0;
    tick(); chk(req, 32'(dq_out), 32'(exp));
    chk(req, 32'(dq_oe), 32'hF);
    cas_n = 4'hF; ras_n = 1;
    tick(); chk("R6 off when both strobes high", 32'(dq_oe), 0);
  endtask

  task automatic cbr(logic w);
    tick(); cas_n = 4'h0; addr = '1;
    tick(); ras_n = 0; we_n = w;
    tick(); chk("R8 refresh drives nothing", 32'(dq_oe), 0);
    ras_n = 1; we_n = 1;
    tick(); cas_n = 4'hF;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 dq_oe", 32'(dq_oe), 0);
    chk("R1 refresh_row", 32'(refresh_row), 0);
    chk("R1 test_mode", 32'(test_mode), 0);
    chk("R1 self_refresh", 32'(self_refresh), 0);
  endtask

  task automatic t_read_write();
    wr_word(5, 2, 4'hF, 4'hA);
    wr_word(2, 1, 4'hF, 4'h3);
    wr_word(5, 1, 4'hF, 4'h9);
    rd_check("R2 read row5 col2", 5, 2, 4'hA);
    rd_check("R2 read row2 col1", 2, 1, 4'h3);
    rd_check("R2 read row5 col1", 5, 1, 4'h9);
  endtask

  task automatic t_lanes();
    wr_word(5, 2, 4'b0101, 4'h5);
    rd_check("R3 masked write", 5, 2, 4'hF);
    wr_word(5, 2, 4'b1010, 4'h0);
    rd_check("R3 masked write upper", 5, 2, 4'h5);
    tick(); addr = 3'd5; ras_n = 0;
    tick(); addr = 3'd2; cas_n = 4'b1101;
    tick(); chk("R3 single lane drive", 32'(dq_oe), 32'h2);
    chk("R3 single lane data", 32'(dq_out[1]), 0);
    cas_n = 4'hF; ras_n = 1;
    tick();
  endtask

  task automatic t_late_write();
    tick(); addr = 3'd2; ras_n = 0;
    tick(); addr = 3'd1; cas_n = 4'h0;
    tick(); chk("R5 read before write", 32'(dq_out), 32'h3);
    we_n = 0; dq_in = 4'hC;
    tick(); chk("R6 write low disables drive", 32'(dq_oe), 0);
    we_n = 1; cas_n = 4'hF; ras_n = 1;
    tick();
    rd_check("R5 late write stored", 2, 1, 4'hC);
  endtask

  task automatic t_page_edo();
    wr_word(5, 3, 4'hF, 4'h6);
    tick(); addr = 3'd5; ras_n = 0;
    tick(); addr = 3'd2; cas_n = 4'h0;
    tick(); chk("R7 page first col", 32'(dq_out), 32'h5);
    cas_n = 4'hF; addr = 3'd0;
    tick(); chk("R6 data held after cas rise", 32'(dq_oe), 32'hF);
    chk("R6 data value held", 32'(dq_out), 32'h5);
    oe_n = 1;
    tick(); chk("R6 oe high disables", 32'(dq_oe), 0);
    oe_n = 0; addr = 3'd3; cas_n = 4'h0;
    tick(); chk("R7 page second col", 32'(dq_out), 32'h6);
    cas_n = 4'hF;
    tick(); addr = 3'd1; cas_n = 4'h0;
    tick(); chk("R7 page third col", 32'(dq_out), 32'h9);
    cas_n = 4'hF; ras_n = 1;
    tick();
  endtask

  task automatic t_refresh();
    for (int k = 0; k < 9; k++) begin
      cbr(1'b1);
      exp_ref = (exp_ref + 1) % 8;
      chk("R8 refresh row step", 32'(refresh_row), 32'(exp_ref));
    end
    rd_check("R8 refresh leaves array", 5, 2, 4'h5);
  endtask

  task automatic t_test_mode();
    cbr(1'b0);
    chk("R9 test mode set", 32'(test_mode), 1);
    chk("R9 no advance", 32'(refresh_row), 32'(exp_ref));
    cbr(1'b1);
    exp_ref = (exp_ref + 1) % 8;
    chk("R9 test mode cleared", 32'(test_mode), 0);
    chk("R9 plain refresh advances", 32'(refresh_row), 32'(exp_ref));
  endtask

  task automatic t_self_refresh();
    tick(); cas_n = 4'h0;
    tick(); ras_n = 0;
    repeat (4) tick();
    chk("R10 not yet self refresh", 32'(self_refresh), 0);
    repeat (6) tick();
    chk("R10 self refresh entered", 32'(self_refresh), 1);
    chk("R10 first self step", 32'(refresh_row), 32'((exp_ref + 1) % 8));
    repeat (10) tick();
    ras_n = 1;
    tick();
    exp_ref = (exp_ref + 3) % 8;
    chk("R10 self refresh left", 32'(self_refresh), 0);
    chk("R10 total steps", 32'(refresh_row), 32'(exp_ref));
    cas_n = 4'hF;
    tick();
  endtask

  task automatic t_hidden();
    tick(); addr = 3'd2; ras_n = 0;
    tick(); addr = 3'd1; cas_n = 4'h0;
    tick(); chk("R11 read data", 32'(dq_out), 32'hC);
    ras_n = 1;
    tick(); chk("R11 held after ras rise", 32'(dq_oe), 32'hF);
    ras_n = 0;
    tick(); ras_n = 1;
    tick();
    exp_ref = (exp_ref + 1) % 8;
    chk("R11 hidden refresh advances", 32'(refresh_row), 32'(exp_ref));
    chk("R11 still driven", 32'(dq_oe), 32'hF);
    chk("R11 data kept", 32'(dq_out), 32'hC);
    cas_n = 4'hF;
    tick(); chk("R6 released after cas rise", 32'(dq_oe), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_read_write();
    t_lanes();
    t_late_write();
    t_page_edo();
    t_refresh();
    t_test_mode();
    t_self_refresh();
    t_hidden();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule